// File: doc/BRIEF.md
# Write-Protection Register with One-Time Lock

This unit sits next to the serial command decoder of a word-organised serial memory. The decoder finishes shifting an instruction and then gives this unit one strobe together with the level of the protection-select pin, the two op-code bits and the address field. From these the unit keeps a boundary address outside the array. Every word from that boundary up to the top of memory is write-protected. A separate "cleared" state means no word is protected. A one-time lock bit can freeze the register for good.

The write paths ask the unit whether a target may be programmed. A single-word write looks at its own address. A page write looks at its whole aligned group of four words and is refused if any of them is protected. Write-all is permitted only while the register is cleared. After each accepted protection-register programming command the unit raises a one-cycle pulse, so the controller can show ready/busy status on the data output. No such pulse is raised once the lock is set.

Top module: `prot_unit`

## Requirements
- R1: After reset the register is cleared, the boundary reads all ones, the lock bit is 0, the enable tracker is clear, and every write target is allowed.
- R2: Protection commands are decoded only when `cmd_pre` is 1 at the strobe. With `cmd_pre` at 0 the same op-code changes no protection state and raises no pulse.
- R3: Op-code 01 (protection write) stores `cmd_addr` as the boundary and leaves the cleared state. A single write is then allowed only if its address is below the boundary.
- R4: A page write (`wr_page`=1) covers the four words that share `wr_addr` except for its two low bits. It is allowed only if all four lie below the boundary, which means the address with its low two bits forced to 11 must be below the boundary.
- R5: Op-code 11 with an all-ones address (protection clear) returns the register to the cleared state. Op-code 11 with any other address is not a protection command.
- R6: `wral_ok` is 1 exactly while the register is in the cleared state.
- R7: Op-code 00 with an all-zero address (protection disable) sets the lock bit only if the immediately preceding strobe was a protection enable. A protection enable is op-code 00 with the top two address bits 11 and `cmd_pre`=1. Any other strobe in between, including one with `cmd_pre`=0, cancels that permission.
- R8: Once set, the lock bit never clears. After that, protection write and clear leave the boundary and the cleared state unchanged.
- R9: `pr_prog` is a one-cycle pulse, seen in the cycle after the strobe, for each accepted protection write, clear or disable. It is never raised while the lock bit is set.
- R10: `rd_word` holds the boundary in its upper bits and the lock bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stb | input | 1 | One-cycle strobe: a complete instruction was decoded |
| cmd_pre | input | 1 | Protection-select pin level for this instruction |
| cmd_op | input | 2 | Op-code bits of the instruction |
| cmd_addr | input | AW | Address field of the instruction |
| wr_addr | input | AW | Target address asked about by the write path |
| wr_page | input | 1 | 1 when the target is a four-word page write |
| wr_allow | output | 1 | Target may be programmed |
| wral_ok | output | 1 | Write-all permitted |
| pr_prog | output | 1 | Accepted protection programming command; show status |
| rd_word | output | AW+1 | Boundary address followed by lock bit |

## Verification
The checker runs on every cycle. It checks that the lock bit never falls and that a locked register keeps its contents. It also checks that a disable without a directly preceding enable never sets the lock, that the cleared state allows every target and write-all, and that no programming pulse appears while locked. Only the bench scenarios can show the rest. These are the exact boundary comparisons for single and page targets, the decode of each op-code and address pattern, and the effect of the select pin. They also cover cancelling the enable tracker with an intervening strobe, and the values read back before and after locking.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [2:0] {
    PC_NONE  = 3'd0,
    PC_READ  = 3'd1,
    PC_WRITE = 3'd2,
    PC_CLEAR = 3'd3,
    PC_EN    = 3'd4,
    PC_DIS   = 3'd5
  } pcmd_e;

  localparam logic [1:0] OP_EXT = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam logic [1:0] OP_CLR = 2'b11;
endpackage

// File: rtl/prot_decode.sv
module prot_decode
  import prot_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          cmd_stb,
  input  logic          cmd_pre,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  output pcmd_e         kind
);
  logic all_one;
  logic all_zero;
  logic top_en;

  assign all_one  = &cmd_addr;
  assign all_zero = ~|cmd_addr;
  assign top_en   = &cmd_addr[AW-1 -: 2];

  always_comb begin
    kind = PC_NONE;
    if (cmd_stb && cmd_pre) begin
      unique case (cmd_op)
        OP_RD:  kind = PC_READ;
        OP_WR:  kind = PC_WRITE;
        OP_CLR: kind = all_one ? PC_CLEAR : PC_NONE;
        OP_EXT: begin
          if (top_en)        kind = PC_EN;
          else if (all_zero) kind = PC_DIS;
          else               kind = PC_NONE;
        end
        default: kind = PC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/prot_regs.sv
module prot_regs
  import prot_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_stb,
  input  pcmd_e         kind,
  input  logic [AW-1:0] cmd_addr,
  output logic [AW-1:0] bound_q,
  output logic          cleared_q,
  output logic          otp_q,
  output logic          last_en_q,
  output logic          prog_q,
  output logic          wr_ok,
  output logic          clr_ok,
  output logic          dis_ok
);
  assign wr_ok  = (kind == PC_WRITE) && !otp_q;
  assign clr_ok = (kind == PC_CLEAR) && !otp_q;
  assign dis_ok = (kind == PC_DIS) && last_en_q && !otp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q   <= '1;
      cleared_q <= 1'b1;
      otp_q     <= 1'b0;
      last_en_q <= 1'b0;
      prog_q    <= 1'b0;
    end else begin
      prog_q <= wr_ok || clr_ok || dis_ok;
      if (cmd_stb) last_en_q <= (kind == PC_EN);
      if (wr_ok) begin
        bound_q   <= cmd_addr;
        cleared_q <= 1'b0;
      end else if (clr_ok) begin
        bound_q   <= '1;
        cleared_q <= 1'b1;
      end
      if (dis_ok) otp_q <= 1'b1;
    end
  end
endmodule

// File: rtl/prot_guard.sv
module prot_guard #(
  parameter int AW = 7,
  parameter int PW = 2
) (
  input  logic [AW-1:0] bound,
  input  logic          cleared,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_page,
  output logic          wr_allow,
  output logic          wral_ok
);
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << PW) - 1);

  function automatic logic [AW-1:0] top_word(input logic [AW-1:0] a, input logic pg);
    return pg ? (a | LOW_MASK) : a;
  endfunction

  function automatic logic below(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a < b;
  endfunction

  assign wr_allow = cleared || below(top_word(wr_addr, wr_page), bound);
  assign wral_ok  = cleared;
endmodule

// File: rtl/prot_unit.sv
module prot_unit
  import prot_pkg::*;
#(
  parameter int AW = 7,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_stb,
  input  logic          cmd_pre,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_page,
  output logic          wr_allow,
  output logic          wral_ok,
  output logic          pr_prog,
  output logic [AW:0]   rd_word
);
  pcmd_e         kind;
  logic [AW-1:0] bound_q;
  logic          cleared_q;
  logic          otp_q;
  logic          last_en_q;
  logic          wr_ok;
  logic          clr_ok;
  logic          dis_ok;
  logic          dis_cmd;

  prot_decode #(.AW(AW)) u_dec (
    .cmd_stb (cmd_stb),
    .cmd_pre (cmd_pre),
    .cmd_op  (cmd_op),
    .cmd_addr(cmd_addr),
    .kind    (kind)
  );

  prot_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_stb  (cmd_stb),
    .kind     (kind),
    .cmd_addr (cmd_addr),
    .bound_q  (bound_q),
    .cleared_q(cleared_q),
    .otp_q    (otp_q),
    .last_en_q(last_en_q),
    .prog_q   (pr_prog),
    .wr_ok    (wr_ok),
    .clr_ok   (clr_ok),
    .dis_ok   (dis_ok)
  );

  prot_guard #(.AW(AW), .PW(PW)) u_guard (
    .bound   (bound_q),
    .cleared (cleared_q),
    .wr_addr (wr_addr),
    .wr_page (wr_page),
    .wr_allow(wr_allow),
    .wral_ok (wral_ok)
  );

  assign dis_cmd = (kind == PC_DIS);
  assign rd_word = {bound_q, otp_q};
endmodule

// File: rtl/prot_unit_chk.sv
module prot_unit_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bound_q,
  input logic          cleared_q,
  input logic          otp_q,
  input logic          last_en_q,
  input logic          dis_cmd,
  input logic          pr_prog,
  input logic          wr_allow,
  input logic          wral_ok
);
  // R8
  otp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otp_q |=> otp_q);

  // R8
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otp_q |=> ($stable(bound_q) && $stable(cleared_q)));

  // R7
  dis_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_cmd && !last_en_q) |=> (otp_q == $past(otp_q)));

  // R6
  cleared_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cleared_q |-> (wr_allow && wral_ok));

  // R9
  no_prog_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_prog |-> !$past(otp_q));
endmodule

bind prot_unit prot_unit_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bound_q  (bound_q),
  .cleared_q(cleared_q),
  .otp_q    (otp_q),
  .last_en_q(last_en_q),
  .dis_cmd  (dis_cmd),
  .pr_prog  (pr_prog),
  .wr_allow (wr_allow),
  .wral_ok  (wral_ok)
);

// File: tb/prot_unit_bench.sv
module prot_unit_bench;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_stb = 1'b0;
  logic          cmd_pre = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [AW-1:0] wr_addr = '0;
  logic          wr_page = 1'b0;
  logic          wr_allow;
  logic          wral_ok;
  logic          pr_prog;
  logic [AW:0]   rd_word;

  int checks = 0;
  int errors = 0;
  logic last_prog;

  always #5 clk = ~clk;

  prot_unit #(.AW(AW)) u_prot_unit (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_pre(cmd_pre),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .wr_addr(wr_addr),
    .wr_page(wr_page), .wr_allow(wr_allow), .wral_ok(wral_ok),
    .pr_prog(pr_prog), .rd_word(rd_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic pre, input logic [1:0] op, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_pre = pre; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_stb = 1'b0;
    last_prog = pr_prog;
  endtask

  function automatic logic ask_ok(input logic [AW-1:0] b, input logic clr,
                                  input logic [AW-1:0] a, input logic pg);
    logic [AW-1:0] hi;
    hi = pg ? {a[AW-1:2], 2'b11} : a;
    return clr || (hi < b);
  endfunction

  task automatic probe(input string req, input logic [AW-1:0] a, input logic pg, input logic exp);
    wr_addr = a; wr_page = pg;
    #1;
    check(req, wr_allow, exp);
  endtask

  task automatic t_reset();
    check("R1 rd_word", rd_word, {7'h7f, 1'b0});
    check("R1 wral", wral_ok, 1'b1);
    probe("R1 top", 7'h7f, 1'b0, 1'b1);
    probe("R1 page", 7'h7c, 1'b1, 1'b1);
  endtask

  task automatic t_write_bound();
    send(1'b1, 2'b01, 7'h40);
    check("R9 prog on write", last_prog, 1'b1);
    check("R10 rd_word", rd_word, {7'h40, 1'b0});
    check("R6 wral after write", wral_ok, 1'b0);
    probe("R3 below", 7'h3f, 1'b0, ask_ok(7'h40, 1'b0, 7'h3f, 1'b0));
    probe("R3 at bound", 7'h40, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 one cycle", pr_prog, 1'b0);
  endtask

  task automatic t_page();
    probe("R4 group below", 7'h3d, 1'b1, 1'b1);
    send(1'b1, 2'b01, 7'h42);
    probe("R4 straddle page", 7'h40, 1'b1, ask_ok(7'h42, 1'b0, 7'h40, 1'b1));
    probe("R3 single under", 7'h41, 1'b0, 1'b1);
    probe("R4 page high addr", 7'h3c, 1'b1, 1'b1);
  endtask

  task automatic t_pre_low();
    send(1'b0, 2'b01, 7'h10);
    check("R2 no prog", last_prog, 1'b0);
    check("R2 unchanged", rd_word, {7'h42, 1'b0});
    send(1'b0, 2'b11, 7'h7f);
    check("R2 clear ignored", wral_ok, 1'b0);
  endtask

  task automatic t_clear();
    send(1'b1, 2'b11, 7'h7e);
    check("R5 partial clear", wral_ok, 1'b0);
    check("R5 partial no prog", last_prog, 1'b0);
    send(1'b1, 2'b11, 7'h7f);
    check("R9 prog on clear", last_prog, 1'b1);
    check("R5 cleared wral", wral_ok, 1'b1);
    probe("R5 all open", 7'h7f, 1'b1, 1'b1);
    check("R5 rd_word", rd_word, {7'h7f, 1'b0});
  endtask

  task automatic t_disable_seq();
    send(1'b1, 2'b01, 7'h20);
    send(1'b1, 2'b00, 7'h00);
    check("R7 bare disable", rd_word[0], 1'b0);
    check("R7 bare no prog", last_prog, 1'b0);
    send(1'b1, 2'b00, 7'h60);
    send(1'b0, 2'b10, 7'h00);
    send(1'b1, 2'b00, 7'h00);
    check("R7 interrupted", rd_word[0], 1'b0);
    send(1'b1, 2'b00, 7'h60);
    send(1'b1, 2'b10, 7'h00);
    send(1'b1, 2'b00, 7'h00);
    check("R7 read between", rd_word[0], 1'b0);
    send(1'b1, 2'b00, 7'h60);
    check("R9 no prog on enable", last_prog, 1'b0);
    send(1'b1, 2'b00, 7'h00);
    check("R7 lock set", rd_word, {7'h20, 1'b1});
    check("R9 prog on disable", last_prog, 1'b1);
  endtask

  task automatic t_locked();
    send(1'b1, 2'b01, 7'h50);
    check("R9 locked write no prog", last_prog, 1'b0);
    check("R8 write frozen", rd_word, {7'h20, 1'b1});
    send(1'b1, 2'b11, 7'h7f);
    check("R8 clear frozen", wral_ok, 1'b0);
    probe("R8 still protected", 7'h20, 1'b0, 1'b0);
    send(1'b1, 2'b00, 7'h60);
    send(1'b1, 2'b00, 7'h00);
    check("R8 lock stays", rd_word[0], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_bound();
    t_page();
    t_pre_low();
    t_clear();
    t_disable_seq();
    t_locked();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule